// File: doc/BRIEF.md
# Sinc2/Sinc3 Decimation Filter

This block turns a one-bit delta-sigma modulator stream into decimated multi-bit samples. A cascade of integrators runs on every bit clock. Each integrator is a 27-bit accumulator that wraps silently on overflow. Once per decimation period, a cascade of differencing (comb) stages turns the integrator value into a sample. The comb stages work at the same 27-bit width, so the wrap-around of the integrators cancels and the difference stays exact. The sample is then right-justified and presented with a strobe.

A two-bit mode input picks second-order filtering, third-order filtering, or raw capture of the most recent 32 stream bits. A four-bit field sets the period as a power of two. The block samples its configuration only while `enable` is low. Raising `enable` starts a run. Lowering it clears all filter state, so the next run starts again from zero.

Top module: `sinc_decimator`

## Requirements
- R1: `modeSel` selects the function: 2'b01 gives second-order filtering, 2'b10 gives third-order filtering, 2'b11 gives raw capture, and 2'b00 is off. When off, `periodDone` never pulses and `sampleOut` stays zero.
- R2: The period is N = 2^`periodLog2` bit clocks, and one bit is taken on every clock edge while the block is enabled. Count the clock edges from the first edge at which `enable` is high. `periodDone` pulses for one cycle after edge N+1, and again after every further N edges.
- R3: Integrators and comb stages wrap modulo 2^27. In both filter modes, bits 31..27 of `sampleOut` are always zero, and the filtered value is exact modulo 2^27.
- R4: In second-order mode, a stream whose every N-bit window holds W ones gives a steady-state sample of (W·N mod 2^27) shifted right by `periodLog2`−1. The shift is 0 when `periodLog2` is 0.
- R5: In third-order mode, the same stream gives a steady-state sample of (W·N² mod 2^27) shifted right by `periodLog2`.
- R6: `sampleValid` pulses only together with `periodDone`. In second-order mode the first sample after enable is flagged invalid. In third-order mode the first two are flagged invalid. All later samples are valid.
- R7: In raw mode, every period end gives a valid sample holding the last 32 stream bits. Bit 0 is the most recent bit, and bits from before enable read as 0.
- R8: `modeSel` and `periodLog2` are captured while `enable` is low. Changing them while `enable` is high has no effect on the running output.
- R9: One clock edge with `enable` low clears `sampleOut`, `sampleValid` and `periodDone`. The next run restarts its warm-up.
- R10: After reset, `sampleOut`, `sampleValid` and `periodDone` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run control; low clears state and loads configuration |
| bitIn | input | 1 | Modulator bitstream, one bit per clock while enabled |
| modeSel | input | 2 | Function select (off, second order, third order, raw) |
| periodLog2 | input | 4 | Decimation period exponent |
| sampleOut | output | 32 | Justified filter sample or raw bit window |
| sampleValid | output | 1 | Sample at this period end is usable |
| periodDone | output | 1 | One-cycle strobe at each period end |

## Verification
The bench sweeps every period exponent that fits in the cycle budget, for both filter orders. It uses all-zero, all-one, half and three-quarter densities, and it computes the expected sample arithmetically.

The long third-order periods and the second-order period of 16384 make the integrators wrap. A comb that differenced at a wider width without masking would show stray high bits there or return a wrong value. The product W·N^k itself reaches 2^27, so a design that saturated instead of wrapping would also miss.

The bench counts clock edges for every `periodDone` strobe, which catches an off-by-one in the bit counter or in the output register. It checks the warm-up flags per order, since a wrong count of discarded samples would release a partial-history sample as valid. It checks that the raw window is the last 32 bits with the newest bit at bit 0. It changes the configuration during a run, which exposes a block that does not hold its settings while enabled.

// File: rtl/sinc_decimator_pkg.sv
package sinc_decimator_pkg;

  localparam int PERIOD_W = 4;
  localparam int CNT_W    = 1 << PERIOD_W;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_SINC2 = 2'b01,
    MODE_SINC3 = 2'b10,
    MODE_RAW   = 2'b11
  } decMode_e;

  // strobes and held configuration passed from control to datapath
  typedef struct packed {
    logic                clear;
    logic                integrate;
    logic                snap;
    logic                snapValid;
    decMode_e            mode;
    logic [PERIOD_W-1:0] shiftAmt;
  } ctlStrobe_t;

endpackage

// File: rtl/sinc_decimator_comb.sv
// One differencing stage. Working at the integrator width makes the
// subtraction modulo 2^ACC_W, so integrator wrap cancels out.
module sinc_decimator_comb #(
  parameter int ACC_W = 27
) (
  input  logic [ACC_W-1:0] curVal,
  input  logic [ACC_W-1:0] prevVal,
  output logic [ACC_W-1:0] diffVal
);

  assign diffVal = curVal - prevVal;

endmodule

// File: rtl/sinc_decimator_ctl.sv
module sinc_decimator_ctl
  import sinc_decimator_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [1:0]          modeSel,
  input  logic [PERIOD_W-1:0] periodLog2,
  output ctlStrobe_t          ctl
);

  decMode_e            cfgMode;
  logic [PERIOD_W-1:0] cfgLog2;
  logic [CNT_W-1:0]    bitCnt;
  logic [CNT_W-1:0]    lastCnt;
  logic                snapPend;
  logic [1:0]          warmCnt;
  logic [1:0]          needWarm;
  logic                active;
  logic                atLast;

  assign active  = enable && (cfgMode != MODE_OFF);
  assign lastCnt = (CNT_W'(1) << cfgLog2) - CNT_W'(1);
  assign atLast  = (bitCnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgMode  <= MODE_OFF;
      cfgLog2  <= '0;
      bitCnt   <= '0;
      snapPend <= 1'b0;
      warmCnt  <= '0;
    end else begin
      if (!enable) begin
        cfgMode <= decMode_e'(modeSel);
        cfgLog2 <= periodLog2;
      end
      if (!active) begin
        bitCnt   <= '0;
        snapPend <= 1'b0;
        warmCnt  <= '0;
      end else begin
        bitCnt   <= atLast ? '0 : bitCnt + CNT_W'(1);
        snapPend <= atLast;
        if (snapPend && (warmCnt < 2'd2)) warmCnt <= warmCnt + 2'd1;
      end
    end
  end

  always_comb begin
    case (cfgMode)
      MODE_SINC2: needWarm = 2'd1;
      MODE_SINC3: needWarm = 2'd2;
      default:    needWarm = 2'd0;
    endcase
  end

  always_comb begin
    ctl.clear     = !active;
    ctl.integrate = active;
    ctl.snap      = snapPend && active;
    ctl.snapValid = snapPend && active && (warmCnt >= needWarm);
    ctl.mode      = cfgMode;
    case (cfgMode)
      MODE_SINC2: ctl.shiftAmt = (cfgLog2 == '0) ? '0 : cfgLog2 - PERIOD_W'(1);
      MODE_SINC3: ctl.shiftAmt = cfgLog2;
      default:    ctl.shiftAmt = '0;
    endcase
  end

endmodule

// File: rtl/sinc_decimator_dp.sv
module sinc_decimator_dp
  import sinc_decimator_pkg::*;
#(
  parameter int ACC_W = 27,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitIn,
  input  ctlStrobe_t       ctl,
  output logic [OUT_W-1:0] sampleOut,
  output logic             sampleValid,
  output logic             periodDone
);

  localparam int STAGES = 3;
  localparam int PAD_W  = OUT_W - ACC_W;

  logic [ACC_W-1:0] integ     [STAGES];
  logic [ACC_W-1:0] integNext [STAGES];
  logic [ACC_W-1:0] combPrev  [STAGES];
  logic [ACC_W-1:0] stageVal  [STAGES+1];
  logic [ACC_W-1:0] filtered;
  logic [OUT_W-1:0] rawShift;
  logic [OUT_W-1:0] justified;

  // integrator cascade uses the freshly updated value of the previous stage
  always_comb begin
    integNext[0] = integ[0] + {{(ACC_W-1){1'b0}}, bitIn};
    for (int s = 1; s < STAGES; s++) integNext[s] = integ[s] + integNext[s-1];
  end

  assign stageVal[0] = (ctl.mode == MODE_SINC3) ? integ[2] : integ[1];

  for (genvar g = 0; g < STAGES; g++) begin : g_comb
    sinc_decimator_comb #(.ACC_W(ACC_W)) u_comb (
      .curVal (stageVal[g]),
      .prevVal(combPrev[g]),
      .diffVal(stageVal[g+1])
    );
  end

  assign filtered  = (ctl.mode == MODE_SINC3) ? stageVal[3] : stageVal[2];
  assign justified = {{PAD_W{1'b0}}, filtered} >> ctl.shiftAmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) begin
        integ[s]    <= '0;
        combPrev[s] <= '0;
      end
      rawShift    <= '0;
      sampleOut   <= '0;
      sampleValid <= 1'b0;
      periodDone  <= 1'b0;
    end else if (ctl.clear) begin
      for (int s = 0; s < STAGES; s++) begin
        integ[s]    <= '0;
        combPrev[s] <= '0;
      end
      rawShift    <= '0;
      sampleOut   <= '0;
      sampleValid <= 1'b0;
      periodDone  <= 1'b0;
    end else begin
      if (ctl.integrate) begin
        for (int s = 0; s < STAGES; s++) integ[s] <= integNext[s];
        rawShift <= {rawShift[OUT_W-2:0], bitIn};
      end
      periodDone  <= ctl.snap;
      sampleValid <= ctl.snapValid;
      if (ctl.snap) begin
        for (int s = 0; s < STAGES; s++) combPrev[s] <= stageVal[s];
        sampleOut <= (ctl.mode == MODE_RAW) ? rawShift : justified;
      end
    end
  end

endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator
  import sinc_decimator_pkg::*;
#(
  parameter int ACC_W = 27,
  parameter int OUT_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                bitIn,
  input  logic [1:0]          modeSel,
  input  logic [PERIOD_W-1:0] periodLog2,
  output logic [OUT_W-1:0]    sampleOut,
  output logic                sampleValid,
  output logic                periodDone
);

  ctlStrobe_t ctlBus;
  decMode_e   cfgModeTap;

  assign cfgModeTap = ctlBus.mode;

  sinc_decimator_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .modeSel   (modeSel),
    .periodLog2(periodLog2),
    .ctl       (ctlBus)
  );

  sinc_decimator_dp #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .bitIn      (bitIn),
    .ctl        (ctlBus),
    .sampleOut  (sampleOut),
    .sampleValid(sampleValid),
    .periodDone (periodDone)
  );

endmodule

// File: rtl/sinc_decimator_checker.sv
module sinc_decimator_checker
  import sinc_decimator_pkg::*;
#(
  parameter int ACC_W = 27,
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input decMode_e         cfgMode,
  input logic [OUT_W-1:0] sampleOut,
  input logic             sampleValid,
  input logic             periodDone
);

  assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == MODE_OFF) |-> !periodDone);

  assert_no_high_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (periodDone && (cfgMode == MODE_SINC2 || cfgMode == MODE_SINC3))
      |-> (sampleOut[OUT_W-1:ACC_W] == '0));

  assert_valid_with_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> periodDone);

  assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(enable) |-> $stable(cfgMode));

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!periodDone && !sampleValid && sampleOut == '0));

endmodule

bind sinc_decimator sinc_decimator_checker #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .cfgMode    (cfgModeTap),
  .sampleOut  (sampleOut),
  .sampleValid(sampleValid),
  .periodDone (periodDone)
);

// File: tb/test_sinc_decimator.sv
module test_sinc_decimator;

  localparam int ACC_W = 27;
  localparam int OUT_W = 32;

  logic             clk = 1'b0;
  logic             rstN;
  logic             enable;
  logic             bitIn;
  logic [1:0]       modeSel;
  logic [3:0]       periodLog2;
  logic [OUT_W-1:0] sampleOut;
  logic             sampleValid;
  logic             periodDone;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sinc_decimator #(.ACC_W(ACC_W), .OUT_W(OUT_W)) i_sinc_decimator (
    .clk(clk), .rstN(rstN), .enable(enable), .bitIn(bitIn),
    .modeSel(modeSel), .periodLog2(periodLog2),
    .sampleOut(sampleOut), .sampleValid(sampleValid), .periodDone(periodDone)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // kind 0: k ones out of every p bits; kind 1: irregular pattern
  function automatic bit patBit(input int kind, input int k, input int p, input int idx);
    if (kind == 0) return (idx % p) < k;
    return ((idx * 5 + (idx >> 2)) % 7) < 3;
  endfunction

  function automatic longint sincExpect(input int order, input int lg, input int k, input int p);
    longint n, v;
    int sh;
    n = longint'(1) << lg;
    v = (longint'(k) * n) / p;
    for (int i = 1; i < order; i++) v = v * n;
    v = v & ((longint'(1) << ACC_W) - 1);
    sh = (order == 3) ? lg : ((lg == 0) ? 0 : lg - 1);
    return v >> sh;
  endfunction

  function automatic longint rawExpect(input int kind, input int k, input int p, input int last);
    longint r = 0;
    for (int j = 0; j < 32; j++)
      if ((last - j) >= 0 && patBit(kind, k, p, last - j)) r = r | (longint'(1) << j);
    return r;
  endfunction

  task automatic runCase(input int mode, input int lg, input int kind, input int k,
                         input int p, input int periods, input bit disturb);
    int n, total, doneCnt, expCnt, need, order;
    string tag;
    n = 1 << lg;
    total = periods * n + 2;
    doneCnt = 0;
    expCnt = 0;
    need  = (mode == 2) ? 2 : ((mode == 1) ? 1 : 0);
    order = (mode == 2) ? 3 : 2;
    tag = disturb ? "R8 config held" :
          (mode == 1) ? "R1/R3/R4 sinc2 value" :
          (mode == 2) ? "R1/R3/R5 sinc3 value" : "R1/R7 raw window";
    @(negedge clk);
    enable = 1'b0; modeSel = mode[1:0]; periodLog2 = lg[3:0]; bitIn = 1'b0;
    @(negedge clk);
    for (int cyc = 0; cyc <= total; cyc++) begin
      bit expDone;
      expDone = (mode != 0) && (cyc >= n + 1) && (((cyc - 1) % n) == 0);
      if (expDone) expCnt++;
      if (periodDone) doneCnt++;
      if (expDone || periodDone) begin
        check(periodDone == expDone, "R2 done timing", longint'(periodDone), longint'(expDone));
        if (expDone) begin
          int kk;
          bit expValid;
          longint expVal;
          kk = (cyc - 1) / n;
          expValid = (mode == 3) || (kk > need);
          check(sampleValid == expValid, "R6 warm-up valid", longint'(sampleValid), longint'(expValid));
          if (expValid) begin
            expVal = (mode == 3) ? rawExpect(kind, k, p, cyc - 2) : sincExpect(order, lg, k, p);
            check(longint'(sampleOut) == expVal, tag, longint'(sampleOut), expVal);
          end
        end
      end
      bitIn = patBit(kind, k, p, cyc);
      enable = 1'b1;
      if (disturb && cyc == n / 2) begin
        modeSel = ~mode[1:0];
        periodLog2 = lg[3:0] ^ 4'd1;
      end
      @(negedge clk);
    end
    check(doneCnt == expCnt, (mode == 0) ? "R1 off mode silent" : "R2 period count",
          longint'(doneCnt), longint'(expCnt));
    if (mode == 0) check(sampleOut == '0, "R1 off mode output", longint'(sampleOut), 0);
    enable = 1'b0;
    @(negedge clk);
    check(!periodDone && !sampleValid && sampleOut == '0, "R9 disable clears",
          longint'(sampleOut), 0);
  endtask

  initial begin
    rstN = 1'b0; enable = 1'b0; bitIn = 1'b0; modeSel = 2'b00; periodLog2 = 4'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sampleOut == '0 && !sampleValid && !periodDone, "R10 reset state",
          longint'(sampleOut), 0);

    for (int lg = 0; lg <= 7; lg++) begin
      runCase(1, lg, 0, 1, 1, 4, 0);
      runCase(1, lg, 0, 0, 1, 4, 0);
      if (lg >= 1) runCase(1, lg, 0, 1, 2, 4, 0);
      if (lg >= 2) runCase(1, lg, 0, 3, 4, 4, 0);
    end
    for (int lg = 0; lg <= 9; lg++) begin
      runCase(2, lg, 0, 1, 1, 5, 0);
      runCase(2, lg, 0, 0, 1, 5, 0);
      if (lg >= 1) runCase(2, lg, 0, 1, 2, 5, 0);
      if (lg >= 2) runCase(2, lg, 0, 3, 4, 5, 0);
    end
    // long second-order periods: R3 wrap at the top of the range
    runCase(1, 13, 0, 1, 1, 3, 0);
    runCase(1, 14, 0, 3, 4, 3, 0);
    // raw capture, R7
    runCase(3, 0, 1, 0, 1, 4, 0);
    runCase(3, 3, 1, 0, 1, 4, 0);
    runCase(3, 5, 1, 0, 1, 4, 0);
    runCase(3, 6, 1, 0, 1, 4, 0);
    // off mode, R1
    runCase(0, 3, 0, 1, 1, 4, 0);
    // configuration changed mid-run, R8
    runCase(2, 4, 0, 1, 2, 5, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule